// File: doc/BRIEF.md
# Bit-Continuous Sample Block Packer

This block turns acquired sample data into an output byte stream. Once a start pulse (a trigger or a stream enable) arrives, it emits a two-byte header that carries the stream identifier. After that, each accepted sample-time strobe produces one block of bytes. A block holds the samples of the enabled channels in an eight-channel converter group, packed back to back with no alignment between samples. Zero bits pad the end of each block to a whole byte.

Every strobe carries eight lane words, a channel mask and a resolution code. The block captures all three at the moment it accepts the strobe. The byte output uses valid/ready flow control. While a block or the header is still in flight, the block does not accept another strobe. It drops that strobe and raises a sticky overflow flag instead.

Top module: `sample_block_packer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` low and `overflow` low, and the block leaves streaming mode.
- R2: A `start` pulse sampled while `out_valid` is low puts the block in streaming mode. The next cycle presents byte 0xA5, followed by the `stream_id` value captured with that pulse.
- R3: A `smp_strobe` that arrives before any accepted `start` produces no output bytes and does not set `overflow`.
- R4: Enabled channels are packed in ascending index order, most significant bit first within each sample. Lane c occupies `smp_data[c*14 +: 14]`, and a sample uses the low bits of its lane.
- R5: `res_sel` encodes the sample width: 0 selects 8 bits, 1 selects 12 bits, and 2 or 3 selects 14 bits.
- R6: A block is ceil(enabled_channels × width / 8) bytes long, and its unused trailing bits are zero. The first block byte appears in the cycle after the accepted strobe.
- R7: A strobe accepted with an all-zero channel mask produces no bytes.
- R8: A `smp_strobe` that arrives in streaming mode while `out_valid` is high is dropped and sets `overflow`. The flag stays set until an accepted `start` or a reset clears it.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R10: A `start` that arrives while `out_valid` is high is ignored. It neither re-sends the header nor clears `overflow`.
- R11: When an accepted `start` and a `smp_strobe` arrive in the same cycle, the start takes priority: only the header is sent, and `overflow` ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Trigger or stream-enable pulse that begins output |
| stream_id | input | 8 | Identifier placed in the header |
| smp_strobe | input | 1 | Sample-time strobe |
| smp_data | input | 112 | Eight 14-bit lane words, lane c at bits c*14 upward |
| ch_en | input | 8 | Channel enable mask, bit c enables lane c |
| res_sel | input | 2 | Sample width code |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Output byte |
| overflow | output | 1 | Sticky dropped-strobe flag |

## Verification
The hardest case to reach is a strobe that arrives exactly while the last byte of a block is being accepted. It has to be dropped, even though the block becomes free on the very next cycle. A start or strobe that lands on a busy cycle is just as awkward. To reach these cases, the stimulus holds `out_ready` low to keep a block in flight, fires extra strobes and starts into it, and then runs hundreds of random masks, widths and strobe spacings against random ready patterns. The reference model uses a bit queue that it builds per channel, so its padding and ordering arithmetic is independent of the design's.

// File: rtl/sbp_pkg.sv
// Shared constants and helpers for the sample block packer.
// Assumes lane words are at least 14 bits wide.
package sbp_pkg;

    localparam logic [7:0] HDR_MARK = 8'hA5;
    localparam int         HDR_BYTES = 2;

    // Map the width code to a sample width in bits (R5).
    function automatic int width_of(input logic [1:0] code);
        case (code)
            2'd0:    return 8;
            2'd1:    return 12;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/sbp_lane_packer.sv
// Combinational packer: concatenates the low bits of each enabled lane,
// ascending lane index, MSB first, left-justified in a wide vector, and
// reports the padded length of the block in bytes.
// Assumes MAX_RES >= 14 so every width code fits in a lane.
module sbp_lane_packer
    import sbp_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int MAX_RES = 14
) (
    input  logic [NUM_CH*MAX_RES-1:0]                     lanes,
    input  logic [NUM_CH-1:0]                             ch_en,
    input  logic [1:0]                                    res_sel,
    output logic [NUM_CH*MAX_RES-1:0]                     packed_bits,
    output logic [$clog2((NUM_CH*MAX_RES+7)/8+1)-1:0]     nbytes
);
    localparam int TOTAL_BITS = NUM_CH * MAX_RES;
    localparam int MAX_BYTES  = (TOTAL_BITS + 7) / 8;
    localparam int CNT_W      = $clog2(MAX_BYTES + 1);
    localparam int IDX_W      = $clog2(TOTAL_BITS);

    // Walk the lanes, placing each enabled sample after the previous one.
    always_comb begin
        int off;
        int w;
        off         = 0;
        w           = width_of(res_sel);
        packed_bits = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_en[c]) begin
                for (int b = 0; b < MAX_RES; b++) begin
                    if (b < w) begin
                        packed_bits[IDX_W'(TOTAL_BITS - 1 - off - b)] =
                            lanes[IDX_W'(c * MAX_RES + w - 1 - b)];
                    end
                end
                off = off + w;
            end
        end
        nbytes = CNT_W'((off + 7) / 8);
    end

endmodule

// File: rtl/sbp_byte_shifter.sv
// Byte serializer: holds a left-justified bit vector and a byte count,
// presents the top byte with valid/ready, shifts by a byte per transfer.
// Assumes load is only asserted while no byte is pending.
module sbp_byte_shifter #(
    parameter int TOTAL_BITS = 112,
    parameter int CNT_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [TOTAL_BITS-1:0] load_vec,
    input  logic [CNT_W-1:0]      load_cnt,
    input  logic                  out_ready,
    output logic                  out_valid,
    output logic [7:0]            out_data
);
    logic [TOTAL_BITS-1:0] vec_q;
    logic [CNT_W-1:0]      cnt_q;

    // Load a new frame, or retire the front byte on a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            vec_q <= load_vec;
            cnt_q <= load_cnt;
        end else if (out_valid && out_ready) begin
            vec_q <= {vec_q[TOTAL_BITS-9:0], 8'h00};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign out_valid = (cnt_q != '0);
    assign out_data  = vec_q[TOTAL_BITS-1 -: 8];

endmodule

// File: rtl/sbp_ctrl.sv
// Stream control: tracks streaming mode, decides when a header or a
// block is loaded, and keeps the sticky overflow flag.
// Assumes busy is the serializer's pending-byte indication.
module sbp_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic smp_strobe,
    input  logic busy,
    output logic load_hdr,
    output logic load_blk,
    output logic overflow
);
    logic streaming_q;

    assign load_hdr = start && !busy;
    assign load_blk = smp_strobe && streaming_q && !busy && !start;

    // Enter streaming on an accepted start; set or clear overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streaming_q <= 1'b0;
            overflow    <= 1'b0;
        end else if (load_hdr) begin
            streaming_q <= 1'b1;
            overflow    <= 1'b0;
        end else if (smp_strobe && streaming_q && busy) begin
            overflow    <= 1'b1;
        end
    end

endmodule

// File: rtl/sample_block_packer.sv
// Top: header then per-strobe blocks of bit-continuous samples, one
// byte per handshake. Assumes NUM_CH*MAX_RES >= 16.
module sample_block_packer
    import sbp_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int MAX_RES = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [7:0]                stream_id,
    input  logic                      smp_strobe,
    input  logic [NUM_CH*MAX_RES-1:0] smp_data,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [1:0]                res_sel,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [7:0]                out_data,
    output logic                      overflow
);
    localparam int TOTAL_BITS = NUM_CH * MAX_RES;
    localparam int MAX_BYTES  = (TOTAL_BITS + 7) / 8;
    localparam int CNT_W      = $clog2(MAX_BYTES + 1);

    logic                  load_hdr;
    logic                  load_blk;
    logic [TOTAL_BITS-1:0] blk_vec;
    logic [CNT_W-1:0]      blk_bytes;
    logic [TOTAL_BITS-1:0] ld_vec;
    logic [CNT_W-1:0]      ld_cnt;

    sbp_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .smp_strobe (smp_strobe),
        .busy       (out_valid),
        .load_hdr   (load_hdr),
        .load_blk   (load_blk),
        .overflow   (overflow)
    );

    sbp_lane_packer #(.NUM_CH(NUM_CH), .MAX_RES(MAX_RES)) u_pack (
        .lanes       (smp_data),
        .ch_en       (ch_en),
        .res_sel     (res_sel),
        .packed_bits (blk_vec),
        .nbytes      (blk_bytes)
    );

    // Choose header or block contents for the serializer.
    always_comb begin
        if (load_hdr) begin
            ld_vec = {HDR_MARK, stream_id, {(TOTAL_BITS-16){1'b0}}};
            ld_cnt = CNT_W'(HDR_BYTES);
        end else begin
            ld_vec = blk_vec;
            ld_cnt = blk_bytes;
        end
    end

    sbp_byte_shifter #(.TOTAL_BITS(TOTAL_BITS), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_hdr || load_blk),
        .load_vec  (ld_vec),
        .load_cnt  (ld_cnt),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/sbp_checker.sv
// Port-level properties of the sample block packer, bound to the top.
module sbp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       smp_strobe,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       overflow
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !overflow));

    // R2
    header_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !out_valid) |=> (out_valid && out_data == 8'hA5));

    // R9
    hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> overflow);

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(smp_strobe && out_valid));

    // R11
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !out_valid) |=> !overflow);

endmodule

bind sample_block_packer sbp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .smp_strobe (smp_strobe),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .overflow   (overflow)
);

// File: tb/sample_block_packer_bench.sv
module sample_block_packer_bench;
    localparam int NCH = 8;
    localparam int LW  = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [7:0]       stream_id = 8'h00;
    logic             smp_strobe = 1'b0;
    logic [NCH*LW-1:0] smp_data = '0;
    logic [NCH-1:0]   ch_en = '0;
    logic [1:0]       res_sel = 2'd0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [7:0]       out_data;
    logic             overflow;

    int    vectors = 0;
    int    fails = 0;
    string req = "R1";
    int    ready_mode = 0;
    bit    running = 0;

    byte unsigned q[$];
    bit           m_stream = 0;
    bit           m_ovf = 0;

    always #5 clk = ~clk;

    sample_block_packer u_sample_block_packer (
        .clk(clk), .rst_n(rst_n), .start(start), .stream_id(stream_id),
        .smp_strobe(smp_strobe), .smp_data(smp_data), .ch_en(ch_en),
        .res_sel(res_sel), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .overflow(overflow)
    );

    // Reference block builder: a bit list per enabled channel, then padding.
    task automatic push_block();
        bit bits[$];
        int w;
        w = (res_sel == 2'd0) ? 8 : (res_sel == 2'd1) ? 12 : 14;
        for (int c = 0; c < NCH; c++)
            if (ch_en[c])
                for (int b = w - 1; b >= 0; b--)
                    bits.push_back(smp_data[c*LW + b]);
        while (bits.size() % 8 != 0) bits.push_back(1'b0);
        for (int i = 0; i < bits.size(); i += 8) begin
            byte unsigned v = 0;
            for (int k = 0; k < 8; k++) v = (v << 1) | bits[i+k];
            q.push_back(v);
        end
    endtask

    // Reference model update at each clock edge.
    always @(posedge clk) begin
        bit busy;
        running = 1;
        if (!rst_n) begin
            q.delete();
            m_stream = 0;
            m_ovf = 0;
        end else begin
            busy = (q.size() != 0);
            if (busy && out_ready) void'(q.pop_front());
            if (start && !busy) begin
                m_stream = 1;
                m_ovf = 0;
                q.push_back(8'hA5);
                q.push_back(stream_id);
            end else if (smp_strobe && m_stream) begin
                if (busy) m_ovf = 1;
                else push_block();
            end
        end
    end

    // Compare outputs against the model mid-cycle.
    always @(negedge clk) begin
        if (running) begin
            vectors++;
            if (out_valid !== (q.size() != 0)) begin
                fails++;
                $display("FAIL %s out_valid actual=%b expected=%b", req, out_valid, q.size() != 0);
            end else if (out_valid && out_data !== q[0]) begin
                fails++;
                $display("FAIL %s out_data actual=%02h expected=%02h", req, out_data, q[0]);
            end
            if (overflow !== m_ovf) begin
                fails++;
                $display("FAIL %s overflow actual=%b expected=%b", req, overflow, m_ovf);
            end
        end
        case (ready_mode)
            0:       out_ready <= 1'b1;
            1:       out_ready <= ($urandom % 4) != 0;
            default: out_ready <= 1'b0;
        endcase
    end

    task automatic pulse_start(input logic [7:0] id, input bit with_strobe);
        @(negedge clk);
        start = 1; stream_id = id; smp_strobe = with_strobe;
        @(negedge clk);
        start = 0; smp_strobe = 0;
    endtask

    task automatic strobe(input logic [7:0] m, input logic [1:0] r);
        @(negedge clk);
        smp_strobe = 1; ch_en = m; res_sel = r;
        for (int c = 0; c < NCH; c++) smp_data[c*LW +: LW] = LW'($urandom);
        @(negedge clk);
        smp_strobe = 0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        req = "R3";
        strobe(8'hFF, 2'd0);
        strobe(8'h0F, 2'd2);
        repeat (3) @(negedge clk);
        req = "R2";
        pulse_start(8'h3C, 0);
        drain();
        req = "R4";
        strobe(8'hFF, 2'd0);
        drain();
        req = "R5";
        strobe(8'h81, 2'd3);
        drain();
        strobe(8'h03, 2'd1);
        drain();
        req = "R6";
        strobe(8'hB5, 2'd1);
        drain();
        strobe(8'h01, 2'd2);
        drain();
        req = "R7";
        strobe(8'h00, 2'd2);
        drain();
        req = "R8";
        ready_mode = 2;
        strobe(8'hFF, 2'd0);
        strobe(8'h0F, 2'd1);
        req = "R9";
        repeat (4) @(negedge clk);
        ready_mode = 0;
        req = "R8";
        drain();
        strobe(8'h11, 2'd0);
        drain();
        req = "R10";
        ready_mode = 2;
        strobe(8'hF0, 2'd2);
        pulse_start(8'h77, 0);
        ready_mode = 0;
        drain();
        req = "R11";
        pulse_start(8'h5A, 1);
        drain();
        req = "R6";
        ready_mode = 1;
        for (int i = 0; i < 300; i++) begin
            strobe(8'($urandom), 2'($urandom));
            repeat ($urandom % 12) @(negedge clk);
            if (i % 50 == 49) begin
                req = "R10";
                pulse_start(8'($urandom), ($urandom % 2) == 1);
                req = "R6";
            end
        end
        ready_mode = 0;
        drain();
        req = "R1";
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule